// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt inputs and turns them into two processor request lines and a wakeup line. Each input has its own trigger mode, which selects rising edge, falling edge, both edges, high level, low level or a mix of these. Each input also has a mask, a wakeup enable, a choice between its external line and one shared internal test bit, and a choice of which request line it drives. Edge events are held in two sticky status registers until software clears them. Two read-only views show which inputs are currently active on each request line.

Software sees a small word-addressed register port. Every control register has one address that reads the value and sets the bits written as one, and a second address that clears the bits written as one. This lets one driver change one input's setup without a read-modify-write race against another driver. External inputs are synchronised before detection, so they may be asynchronous to the block clock.

Top module: `irqc_top`

## Requirements
- R1: After reset every control register, both edge registers, both active views and the test bit read 0, and `req0_o`, `req1_o` and `wake_o` are low.
- R2: Word addresses: trig-A 0/1, trig-B 2/3, trig-C 4/5, source 6/7, route 8/9, wake 10/11, mask 12/13 (even = read and set, odd = clear; a read at either returns the value), rise 14, fall 15, active-0 16, active-1 17, test bit 18 (bit 0). A write to an even address sets each bit written as 1 and leaves bits written as 0 unchanged.
- R3: A write to an odd control address clears each bit written as 1 and leaves the other bits unchanged.
- R4: Input n's mode is {trig-C[n],trig-B[n],trig-A[n]}. A 0-to-1 change of its signal sets rise[n] in modes 001, 011 and 111. The bit stays set until a 1 is written to it at address 14.
- R5: A 1-to-0 change sets fall[n] in modes 010, 011 and 111. The bit stays set until a 1 is written to it at address 15.
- R6: Modes 000 and 100 never latch an edge or report the input active. Modes 101 and 110 latch no edges.
- R7: Modes 101 and 111 make the input active while its signal is 1. Modes 110 and 111 make it active while its signal is 0. This needs no clearing.
- R8: Source bit 0 selects the test bit as the input's signal, and source bit 1 selects the external line. An external rising edge shows in the rise register after three clock edges and not after two.
- R9: Route bit 1 sends an active, unmasked input to request 0 and route bit 0 sends it to request 1. Active-0 and active-1 read back pending AND mask AND the routing, and each request output is the OR of its view.
- R10: A mask bit of 0 keeps the input out of both views and requests, but its edges are still latched.
- R11: `wake_o` is high when any input is pending with its wake bit set, whether or not it is masked.
- R12: When a new edge arrives in the same cycle as a clear of that edge bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NUM_IN | Write data |
| bus_rdata | output | NUM_IN | Read data for bus_addr (combinational) |
| irq_in | input | NUM_IN | External interrupt lines, asynchronous |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup-from-idle request |

## Verification
The hardest case to reach is a collision between an edge capture and a software clear of the same bit in the same cycle. A new edge is captured one cycle after the test bit changes. The bench therefore issues a test-bit write and a clear write on back-to-back cycles, so that both reach the edge register at the same clock edge. All eight trigger modes are swept on all 32 inputs at once through the test bit, and the expected latches and active views are computed from the mode bits. The external path is checked one input at a time, with reads taken on each side of the synchroniser delay.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int unsigned ADDR_W   = 5;
   localparam int unsigned N_CTL    = 7;   // control registers with set/clear pairs
   localparam logic [ADDR_W-1:0] AD_RISE = 5'd14;
   localparam logic [ADDR_W-1:0] AD_FALL = 5'd15;
   localparam logic [ADDR_W-1:0] AD_ACT0 = 5'd16;
   localparam logic [ADDR_W-1:0] AD_ACT1 = 5'd17;
   localparam logic [ADDR_W-1:0] AD_TEST = 5'd18;

   // control register slots, address = 2*slot (set) and 2*slot+1 (clear)
   localparam int unsigned CT_TRIGA = 0;
   localparam int unsigned CT_TRIGB = 1;
   localparam int unsigned CT_TRIGC = 2;
   localparam int unsigned CT_SRC   = 3;
   localparam int unsigned CT_ROUTE = 4;
   localparam int unsigned CT_WAKE  = 5;
   localparam int unsigned CT_MASK  = 6;

   typedef struct packed {
      logic rise;
      logic fall;
      logic high;
      logic low;
   } trig_en_t;

   // mode = {c, b, a}
   function automatic trig_en_t decode_mode(input logic c, input logic b, input logic a);
      trig_en_t t;
      t.rise = a & (~c | b);
      t.fall = b & (~c | a);
      t.high = c & a;
      t.low  = c & b;
      return t;
   endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("irqc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] set_bits, clr_bits;
   assign set_bits = set_we ? wdata : '0;
   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_bits) & ~clr_bits;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(wdata)) == $past(wdata))); // R2
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((q & $past(wdata)) == '0)); // R3
   AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(q)); // R2
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
   import irqc_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig_i,
   input  logic [WIDTH-1:0] mode_a,
   input  logic [WIDTH-1:0] mode_b,
   input  logic [WIDTH-1:0] mode_c,
   input  logic [WIDTH-1:0] rise_clr,
   input  logic [WIDTH-1:0] fall_clr,
   output logic [WIDTH-1:0] rise_q,
   output logic [WIDTH-1:0] fall_q,
   output logic [WIDTH-1:0] pend_o
);
   logic [WIDTH-1:0] sig_d;
   logic [WIDTH-1:0] rise_en, fall_en, high_en, low_en;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_d <= '0;
      else        sig_d <= sig_i;
   end

   generate
      for (genvar n = 0; n < WIDTH; n++) begin : g_in
         trig_en_t en;
         assign en         = decode_mode(mode_c[n], mode_b[n], mode_a[n]);
         assign rise_en[n] = en.rise;
         assign fall_en[n] = en.fall;
         assign high_en[n] = en.high;
         assign low_en[n]  = en.low;

         // a new edge wins over a simultaneous clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rise_q[n] <= 1'b0;
               fall_q[n] <= 1'b0;
            end else begin
               rise_q[n] <= (rise_q[n] & ~rise_clr[n]) | (rise_en[n] &  sig_i[n] & ~sig_d[n]);
               fall_q[n] <= (fall_q[n] & ~fall_clr[n]) | (fall_en[n] & ~sig_i[n] &  sig_d[n]);
            end
         end

         assign pend_o[n] = rise_q[n] | fall_q[n]
                          | (high_en[n] & sig_i[n]) | (low_en[n] & ~sig_i[n]);
      end
   endgenerate

   AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_q & ~$past(rise_q)) & ~$past(rise_en)) == '0); // R6
   AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((fall_q & ~$past(fall_q)) & ~$past(fall_en)) == '0); // R6
   AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rise_q) & ~$past(rise_clr)) & ~rise_q) == '0); // R4
   AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(fall_q) & ~$past(fall_clr)) & ~fall_q) == '0); // R5
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_IN      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        bus_addr,
   input  logic              bus_we,
   input  logic [NUM_IN-1:0] bus_wdata,
   output logic [NUM_IN-1:0] bus_rdata,
   input  logic [NUM_IN-1:0] irq_in,
   output logic              req0_o,
   output logic              req1_o,
   output logic              wake_o
);
   generate
      if (NUM_IN < 1 || NUM_IN > 32) begin : g_bad_width
         $error("irqc_top: NUM_IN must be 1..32");
      end
   endgenerate

   logic [NUM_IN-1:0] ctl_q [N_CTL];
   logic [NUM_IN-1:0] ext_s, sig, rise_q, fall_q, pend, act0, act1;
   logic [NUM_IN-1:0] rise_clr, fall_clr;
   logic              test_q;

   generate
      for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
         irqc_setclr_reg #(.WIDTH(NUM_IN)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (bus_we && bus_addr == 5'(2*k)),
            .clr_we (bus_we && bus_addr == 5'(2*k+1)),
            .wdata  (bus_wdata),
            .q      (ctl_q[k])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                             test_q <= 1'b0;
      else if (bus_we && bus_addr == AD_TEST) test_q <= bus_wdata[0];
   end

   irqc_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_in),
      .q_o   (ext_s)
   );

   assign sig      = (ctl_q[CT_SRC] & ext_s) | (~ctl_q[CT_SRC] & {NUM_IN{test_q}});
   assign rise_clr = (bus_we && bus_addr == AD_RISE) ? bus_wdata : '0;
   assign fall_clr = (bus_we && bus_addr == AD_FALL) ? bus_wdata : '0;

   irqc_trigger #(.WIDTH(NUM_IN)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_i    (sig),
      .mode_a   (ctl_q[CT_TRIGA]),
      .mode_b   (ctl_q[CT_TRIGB]),
      .mode_c   (ctl_q[CT_TRIGC]),
      .rise_clr (rise_clr),
      .fall_clr (fall_clr),
      .rise_q   (rise_q),
      .fall_q   (fall_q),
      .pend_o   (pend)
   );

   assign act0   = pend & ctl_q[CT_MASK] &  ctl_q[CT_ROUTE];
   assign act1   = pend & ctl_q[CT_MASK] & ~ctl_q[CT_ROUTE];
   assign req0_o = |act0;
   assign req1_o = |act1;
   assign wake_o = |(pend & ctl_q[CT_WAKE]);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr < 5'(2*N_CTL)) bus_rdata = ctl_q[bus_addr[4:1]];
      else begin
         case (bus_addr)
            AD_RISE: bus_rdata = rise_q;
            AD_FALL: bus_rdata = fall_q;
            AD_ACT0: bus_rdata = act0;
            AD_ACT1: bus_rdata = act1;
            AD_TEST: bus_rdata = NUM_IN'(test_q);
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CT_MASK] == '0) |-> (!req0_o && !req1_o)); // R10
   AST_TEST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AD_TEST) |=> (test_q == $past(bus_wdata[0]))); // R8
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
   localparam int N = 32;
   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    addr = '0;
   logic          we = 1'b0;
   logic [N-1:0]  wdata = '0;
   logic [N-1:0]  rdata;
   logic [N-1:0]  irq = '0;
   logic          req0, req1, wake;
   int            checks = 0;
   int            errors = 0;

   always #2.5 clk = ~clk;

   irqc_top #(.NUM_IN(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(irq),
      .req0_o(req0), .req1_o(req1), .wake_o(wake)
   );

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      addr = a; #1;
      chk(tag, rdata, exp);
   endtask

   task automatic set_mode(input int m);
      for (int k = 0; k < 3; k++) begin
         if (m[k]) wr(5'(2*k), ALL); else wr(5'(2*k+1), ALL);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      finish_run();
   end

   initial begin
      logic re, fe, hi, lo;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a <= 18; a++) rchk("R1 reset reg", 5'(a), 32'h0);
      chk("R1 reset outputs", {29'h0, req0, req1, wake}, 32'h0);

      // R2 / R3 set and clear semantics
      wr(5'd0, 32'h0000_00FF);
      wr(5'd0, 32'h0000_0F00);
      rchk("R2 set accumulates", 5'd0, 32'h0000_0FFF);
      rchk("R2 read at clear addr", 5'd1, 32'h0000_0FFF);
      wr(5'd12, 32'hA5A5_A5A5);
      wr(5'd13, 32'h0F0F_0F0F);
      rchk("R3 clear selected bits", 5'd12, 32'hA0A0_A0A0);
      wr(5'd1, ALL); wr(5'd13, ALL);

      // sweep all trigger modes via the test bit, all inputs at once
      wr(5'd12, ALL);      // mask on
      wr(5'd8, ALL);       // route all to request 0
      for (int m = 0; m < 8; m++) begin
         re = (m == 1) || (m == 3) || (m == 7);
         fe = (m == 2) || (m == 3) || (m == 7);
         hi = (m == 5) || (m == 7);
         lo = (m == 6) || (m == 7);
         wr(5'd18, 32'h0);
         set_mode(m);
         idle(2);
         wr(5'd14, ALL); wr(5'd15, ALL);
         idle(1);
         rchk($sformatf("R7 low level mode %0d", m), 5'd16, lo ? ALL : 32'h0);
         wr(5'd18, 32'h1);
         idle(2);
         rchk($sformatf("R4 R6 rise latch mode %0d", m), 5'd14, re ? ALL : 32'h0);
         rchk($sformatf("R6 active after rise mode %0d", m), 5'd16, (re | hi) ? ALL : 32'h0);
         wr(5'd14, ALL);
         idle(1);
         rchk($sformatf("R4 rise cleared, R7 high mode %0d", m), 5'd16, hi ? ALL : 32'h0);
         rchk($sformatf("R5 no fall yet mode %0d", m), 5'd15, 32'h0);
         wr(5'd18, 32'h0);
         idle(2);
         rchk($sformatf("R5 R6 fall latch mode %0d", m), 5'd15, fe ? ALL : 32'h0);
         rchk($sformatf("R9 active0 mode %0d", m), 5'd16, (fe | lo) ? ALL : 32'h0);
         chk($sformatf("R9 request pins mode %0d", m), {30'h0, req0, req1}, {30'h0, (fe | lo), 1'b0});
         idle(3);
         rchk($sformatf("R5 fall sticky mode %0d", m), 5'd15, fe ? ALL : 32'h0);
      end

      // R9 routing split in mode 111 (always pending)
      set_mode(7);
      wr(5'd9, 32'h0000_FFFF);
      idle(1);
      rchk("R9 active0 view", 5'd16, 32'hFFFF_0000);
      rchk("R9 active1 view", 5'd17, 32'h0000_FFFF);
      chk("R9 both requests", {30'h0, req0, req1}, 32'h3);

      // R11 wake with everything masked
      wr(5'd13, ALL);
      wr(5'd10, 32'h0000_0008);
      idle(1);
      chk("R10 masked requests low", {30'h0, req0, req1}, 32'h0);
      rchk("R10 masked active1", 5'd17, 32'h0);
      chk("R11 wake while masked", {31'h0, wake}, 32'h1);
      wr(5'd11, ALL);
      idle(1);
      chk("R11 wake disabled", {31'h0, wake}, 32'h0);

      // R10 edges still latch while masked
      wr(5'd14, ALL); wr(5'd15, ALL);
      set_mode(1);
      wr(5'd18, 32'h1);
      idle(2);
      rchk("R10 masked edge latched", 5'd14, ALL);
      chk("R10 masked edge no request", {30'h0, req0, req1}, 32'h0);

      // R12 edge arriving together with its clear
      wr(5'd18, 32'h0);
      wr(5'd14, ALL);
      idle(2);
      rchk("R12 precondition clear", 5'd14, 32'h0);
      @(negedge clk); addr = 5'd18; wdata = 32'h1; we = 1'b1;
      @(negedge clk); addr = 5'd14; wdata = ALL;
      @(negedge clk); we = 1'b0;
      rchk("R12 new edge wins over clear", 5'd14, ALL);

      // R8 external source on input 5, synchroniser latency
      wr(5'd18, 32'h0);
      wr(5'd14, ALL); wr(5'd15, ALL);
      wr(5'd6, 32'h0000_0020);
      idle(2);
      wr(5'd14, ALL); wr(5'd15, ALL);
      @(negedge clk); irq[5] = 1'b1;
      @(negedge clk); @(negedge clk);
      rchk("R8 not yet after two edges", 5'd14, 32'h0);
      @(negedge clk);
      rchk("R8 external rise after three edges", 5'd14, 32'h0000_0020);
      irq[6] = 1'b1;
      idle(4);
      rchk("R8 input on test source ignores line", 5'd14, 32'h0000_0020);
      wr(5'd18, 32'h1);
      idle(2);
      rchk("R8 test bit drives others only", 5'd14, ALL);

      finish_run();
   end
endmodule